// File: doc/BRIEF.md
# Packet Stream to AXI4-Stream Bridge

This bridge takes a packet stream that marks frames with start and end flags, reports unused trailing bytes of the final beat as a count, and carries a channel number and error bits alongside the data. It presents the same traffic as an AXI4-Stream master. Data, valid and ready pass straight through with no register stage, so the bridge adds no latency and no storage. Backpressure from the sink reaches the source in the same cycle.

The trailing-byte count becomes a contiguous byte mask on TKEEP and TSTRB. The channel number is placed on TID, and any channel bits that do not fit are added to TUSER above the error bits. AXI4-Stream has no start-of-packet signal, so the start flag is not forwarded. Instead, the bridge tracks where a packet should begin: after reset, and after every accepted last beat. If an accepted beat carries a start flag that disagrees with this tracker, a sticky error output is raised.

Top module: `pkt_axis_bridge`

## Requirements
- R1: `m_tdata_o` equals `src_data_i`, `m_tvalid_o` equals `src_valid_i`, and `src_ready_o` equals `m_tready_i`, all in the same cycle with no register in the path.
- R2: `m_tlast_o` follows the source end-of-packet flag.
- R3: On a last beat, byte lane 0 is data bits [7:0] and lanes count upward. An empty count of N clears the top N bits of `m_tkeep_o`, and sets the rest.
- R4: On a beat that is not last, the empty count has no effect and `m_tkeep_o` is all ones.
- R5: `m_tstrb_o` always equals `m_tkeep_o`.
- R6: `m_tid_o` is the low ID_W bits of the channel. `m_tuser_o` holds the error bits in its low ERR_W bits, and the channel bits above ID_W above them.
- R7: A start is expected after reset and after each accepted last beat; any other accepted beat must not carry the start flag. An accepted beat whose start flag disagrees with this expectation sets `sop_err_o` at the clock edge that accepts the beat.
- R8: `sop_err_o` is 0 after reset. Once set, it stays set until the next reset.
- R9: A beat that is presented but not accepted, because ready is low, neither changes the start tracking nor raises `sop_err_o`.
- R10: While `m_tvalid_o` is high and `m_tready_i` is low, the bridge outputs stay unchanged, provided the source holds its inputs.
- R11: An empty count of DATA_BYTES or more is treated as DATA_BYTES-1, so lane 0 of a valid beat is always kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_valid_i | input | 1 | Source beat valid |
| src_ready_o | output | 1 | Ready returned to the source |
| src_data_i | input | DATA_BYTES*8 | Source data |
| src_sop_i | input | 1 | Source start-of-packet flag |
| src_eop_i | input | 1 | Source end-of-packet flag |
| src_empty_i | input | EMPTY_W | Count of unused top bytes on the last beat |
| src_chan_i | input | CHAN_W | Source channel number |
| src_err_i | input | ERR_W | Source error bits |
| m_tvalid_o | output | 1 | TVALID |
| m_tready_i | input | 1 | TREADY |
| m_tdata_o | output | DATA_BYTES*8 | TDATA |
| m_tkeep_o | output | DATA_BYTES | TKEEP |
| m_tstrb_o | output | DATA_BYTES | TSTRB |
| m_tlast_o | output | 1 | TLAST |
| m_tid_o | output | ID_W | TID |
| m_tuser_o | output | USER_W | TUSER |
| sop_err_o | output | 1 | Sticky start-of-packet protocol error |

## Verification
The only state in the bridge is the start tracker and the sticky error bit. A wrong tracker value does not change any data output. It shows up only at `sop_err_o`, one clock edge after the first accepted beat that it misjudges. A stalled beat that wrongly updated the tracker would show the same symptom on the next accepted beat. Mask and sideband errors are combinational, so they appear on the same beat that is transferred. The scoreboard compares every transferred beat.

// File: rtl/pkt_axis_pkg.sv
package pkt_axis_pkg;
  // Width of a count that reaches n-1; at least one bit
  function automatic int cnt_w(input int n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction

  // TUSER carries the error bits plus any channel bits that do not fit in TID
  function automatic int user_w(input int chan_w, input int id_w, input int err_w);
    return err_w + ((chan_w > id_w) ? (chan_w - id_w) : 0);
  endfunction
endpackage

// File: rtl/keep_mask_gen.sv
module keep_mask_gen #(
  parameter int DATA_BYTES = 8,
  parameter int EMPTY_W    = 3
) (
  input  logic                  last_i,
  input  logic [EMPTY_W-1:0]    empty_i,
  output logic [DATA_BYTES-1:0] keep_o
);
  localparam logic [EMPTY_W:0]   BYTES_X = (EMPTY_W+1)'(DATA_BYTES);
  localparam logic [EMPTY_W-1:0] MAX_EMPTY = EMPTY_W'(DATA_BYTES - 1);

  logic [EMPTY_W-1:0] lim;

  // saturate so lane 0 always survives
  always_comb begin
    if ({1'b0, empty_i} >= BYTES_X) lim = MAX_EMPTY;
    else                            lim = empty_i;
  end

  for (genvar g = 0; g < DATA_BYTES; g++) begin : g_lane
    localparam logic [EMPTY_W-1:0] LANE_MAX_EMPTY = EMPTY_W'(DATA_BYTES - 1 - g);
    assign keep_o[g] = ~last_i | (lim <= LANE_MAX_EMPTY);
  end
endmodule

// File: rtl/sideband_map.sv
module sideband_map #(
  parameter int CHAN_W = 6,
  parameter int ID_W   = 4,
  parameter int ERR_W  = 2,
  parameter int USER_W = 4
) (
  input  logic [CHAN_W-1:0] chan_i,
  input  logic [ERR_W-1:0]  err_i,
  output logic [ID_W-1:0]   tid_o,
  output logic [USER_W-1:0] tuser_o
);
  if (CHAN_W > ID_W) begin : g_spill
    assign tid_o   = chan_i[ID_W-1:0];
    assign tuser_o = {chan_i[CHAN_W-1:ID_W], err_i};
  end else begin : g_fit
    assign tid_o   = ID_W'(chan_i);
    assign tuser_o = err_i;
  end
endmodule

// File: rtl/sop_tracker.sv
module sop_tracker (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  input  logic sop_i,
  input  logic eop_i,
  output logic sop_err_o
);
  logic expect_start_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      expect_start_q <= 1'b1;
      sop_err_o      <= 1'b0;
    end else if (fire_i) begin
      expect_start_q <= eop_i;
      if (sop_i != expect_start_q) sop_err_o <= 1'b1;
    end
  end
endmodule

// File: rtl/pkt_axis_bridge.sv
module pkt_axis_bridge
  import pkt_axis_pkg::*;
#(
  parameter int DATA_BYTES = 8,
  parameter int CHAN_W     = 6,
  parameter int ID_W       = 4,
  parameter int ERR_W      = 2,
  localparam int DATA_W    = DATA_BYTES * 8,
  localparam int EMPTY_W   = cnt_w(DATA_BYTES),
  localparam int USER_W    = user_w(CHAN_W, ID_W, ERR_W)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  src_valid_i,
  output logic                  src_ready_o,
  input  logic [DATA_W-1:0]     src_data_i,
  input  logic                  src_sop_i,
  input  logic                  src_eop_i,
  input  logic [EMPTY_W-1:0]    src_empty_i,
  input  logic [CHAN_W-1:0]     src_chan_i,
  input  logic [ERR_W-1:0]      src_err_i,
  output logic                  m_tvalid_o,
  input  logic                  m_tready_i,
  output logic [DATA_W-1:0]     m_tdata_o,
  output logic [DATA_BYTES-1:0] m_tkeep_o,
  output logic [DATA_BYTES-1:0] m_tstrb_o,
  output logic                  m_tlast_o,
  output logic [ID_W-1:0]       m_tid_o,
  output logic [USER_W-1:0]     m_tuser_o,
  output logic                  sop_err_o
);
  logic [DATA_BYTES-1:0] keep;

  assign m_tvalid_o  = src_valid_i;
  assign src_ready_o = m_tready_i;
  assign m_tdata_o   = src_data_i;
  assign m_tlast_o   = src_eop_i;
  assign m_tkeep_o   = keep;
  assign m_tstrb_o   = keep;

  keep_mask_gen #(
    .DATA_BYTES(DATA_BYTES),
    .EMPTY_W   (EMPTY_W)
  ) u_keep (
    .last_i (src_eop_i),
    .empty_i(src_empty_i),
    .keep_o (keep)
  );

  sideband_map #(
    .CHAN_W(CHAN_W),
    .ID_W  (ID_W),
    .ERR_W (ERR_W),
    .USER_W(USER_W)
  ) u_side (
    .chan_i (src_chan_i),
    .err_i  (src_err_i),
    .tid_o  (m_tid_o),
    .tuser_o(m_tuser_o)
  );

  sop_tracker u_sop (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .fire_i   (src_valid_i & m_tready_i),
    .sop_i    (src_sop_i),
    .eop_i    (src_eop_i),
    .sop_err_o(sop_err_o)
  );
endmodule

// File: rtl/pkt_axis_bridge_chk.sv
module pkt_axis_bridge_chk #(
  parameter int DATA_BYTES = 8,
  parameter int DATA_W     = 64
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  m_tvalid_o,
  input logic                  m_tready_i,
  input logic [DATA_W-1:0]     m_tdata_o,
  input logic [DATA_BYTES-1:0] m_tkeep_o,
  input logic                  m_tlast_o,
  input logic                  sop_err_o
);
  // R4
  nonlast_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_tvalid_o && !m_tlast_o) |-> (&m_tkeep_o));

  // R3
  keep_contig_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_tvalid_o |-> ((m_tkeep_o & (m_tkeep_o + DATA_BYTES'(1))) == DATA_BYTES'(0)));

  // R11
  lane0_kept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_tvalid_o |-> m_tkeep_o[0]);

  // R8
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sop_err_o |=> sop_err_o);

  // R7
  err_on_fire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sop_err_o) |-> $past(m_tvalid_o && m_tready_i));

  // R10
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_tvalid_o && !m_tready_i) |=>
      (m_tvalid_o && $stable(m_tdata_o) && $stable(m_tkeep_o) && $stable(m_tlast_o)));
endmodule

bind pkt_axis_bridge pkt_axis_bridge_chk #(
  .DATA_BYTES(DATA_BYTES),
  .DATA_W    (DATA_W)
) u_chk (.*);

// File: tb/pkt_axis_bridge_bench.sv
module pkt_axis_bridge_bench;
  localparam int DB  = 6;
  localparam int DW  = DB * 8;
  localparam int CW  = 6;
  localparam int IW  = 4;
  localparam int EW  = 2;
  localparam int EMW = 3;
  localparam int UW  = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n;
  logic src_valid, src_ready, src_sop, src_eop;
  logic [DW-1:0]  src_data;
  logic [EMW-1:0] src_empty;
  logic [CW-1:0]  src_chan;
  logic [EW-1:0]  src_err;
  logic m_tvalid, m_tready, m_tlast, sop_err;
  logic [DW-1:0] m_tdata;
  logic [DB-1:0] m_tkeep, m_tstrb;
  logic [IW-1:0] m_tid;
  logic [UW-1:0] m_tuser;

  pkt_axis_bridge #(.DATA_BYTES(DB), .CHAN_W(CW), .ID_W(IW), .ERR_W(EW)) u_pkt_axis_bridge (
    .clk_i(clk), .rst_ni(rst_n),
    .src_valid_i(src_valid), .src_ready_o(src_ready), .src_data_i(src_data),
    .src_sop_i(src_sop), .src_eop_i(src_eop), .src_empty_i(src_empty),
    .src_chan_i(src_chan), .src_err_i(src_err),
    .m_tvalid_o(m_tvalid), .m_tready_i(m_tready), .m_tdata_o(m_tdata),
    .m_tkeep_o(m_tkeep), .m_tstrb_o(m_tstrb), .m_tlast_o(m_tlast),
    .m_tid_o(m_tid), .m_tuser_o(m_tuser), .sop_err_o(sop_err)
  );

  typedef struct packed {
    logic [DW-1:0] data;
    logic          last;
    logic [DB-1:0] keep;
    logic [IW-1:0] id;
    logic [UW-1:0] user;
  } exp_t;

  exp_t exp_q[$];
  int n_chk = 0;
  int n_fail = 0;
  logic stall_force = 1'b1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [DB-1:0] exp_keep(input logic last, input logic [EMW-1:0] empty);
    int n;
    if (!last) return '1;
    n = (int'(empty) >= DB) ? DB - 1 : int'(empty);
    return DB'((1 << (DB - n)) - 1);
  endfunction

  // random sink backpressure
  always begin
    @(posedge clk);
    #1;
    m_tready = stall_force ? 1'b0 : ($urandom_range(3) != 0);
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && m_tvalid && m_tready) begin
      chk(src_ready == m_tready, "R1", "ready", 64'(src_ready), 64'(m_tready));
      if (exp_q.size() == 0) begin
        chk(1'b0, "R1", "unexpected beat", 64'(m_tdata), 64'd0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(m_tdata == e.data, "R1", "tdata", 64'(m_tdata), 64'(e.data));
        chk(m_tlast == e.last, "R2", "tlast", 64'(m_tlast), 64'(e.last));
        chk(m_tkeep == e.keep, e.last ? "R3" : "R4", "tkeep", 64'(m_tkeep), 64'(e.keep));
        chk(m_tstrb == e.keep, "R5", "tstrb", 64'(m_tstrb), 64'(e.keep));
        chk(m_tid == e.id, "R6", "tid", 64'(m_tid), 64'(e.id));
        chk(m_tuser == e.user, "R6", "tuser", 64'(m_tuser), 64'(e.user));
      end
    end
  end

  task automatic present(input logic [DW-1:0] d, input logic sop, input logic eop,
                         input logic [EMW-1:0] emp, input logic [CW-1:0] ch,
                         input logic [EW-1:0] er);
    exp_t e;
    src_data = d; src_sop = sop; src_eop = eop; src_empty = emp;
    src_chan = ch; src_err = er; src_valid = 1'b1;
    e.data = d; e.last = eop; e.keep = exp_keep(eop, emp);
    e.id = ch[IW-1:0]; e.user = {ch[CW-1:IW], er};
    exp_q.push_back(e);
  endtask

  // call just after a posedge; returns just after the accepting posedge
  task automatic finish_beat();
    forever begin
      @(negedge clk);
      if (m_tready) break;
    end
    @(posedge clk);
    #2;
    src_valid = 1'b0;
  endtask

  task automatic send_beat(input logic sop, input logic eop, input logic [EMW-1:0] emp,
                           input logic [CW-1:0] ch);
    present({$urandom, $urandom}, sop, eop, emp, ch, EW'($urandom));
    finish_beat();
  endtask

  task automatic send_pkt(input int len, input logic [CW-1:0] ch);
    for (int b = 0; b < len; b++)
      send_beat(b == 0, b == len - 1, EMW'($urandom), ch);
    if ($urandom_range(1) == 0) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(posedge clk);
    #2;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(sop_err == 1'b0, "R8", "sop_err in reset", 64'(sop_err), 64'd0);
    @(posedge clk);
    #2;
    rst_n = 1'b1;
  endtask

  initial begin
    #(20 * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [DW-1:0] hold_d;
    src_valid = 0; src_sop = 0; src_eop = 0; src_empty = 0;
    src_chan = 0; src_err = 0; src_data = 0; m_tready = 0;
    do_reset();

    // R1: ready path is combinational
    stall_force = 1'b0;
    repeat (3) begin
      @(negedge clk);
      chk(src_ready == m_tready, "R1", "idle ready", 64'(src_ready), 64'(m_tready));
      chk(m_tvalid == 1'b0, "R1", "idle valid", 64'(m_tvalid), 64'd0);
    end
    @(posedge clk);
    #2;

    // R3/R11: every empty count on a single-beat packet, including counts >= DB
    for (int e = 0; e < 8; e++) send_beat(1'b1, 1'b1, EMW'(e), CW'(e * 9));
    // R4: multi-beat packets with junk empty on middle beats
    for (int p = 0; p < 40; p++) send_pkt($urandom_range(6, 1), CW'($urandom));
    drain();
    chk(sop_err == 1'b0, "R7", "no error on legal traffic", 64'(sop_err), 64'd0);

    // R9/R10: stalled beat with a missing start flag
    stall_force = 1'b1;
    @(posedge clk);
    #2;
    hold_d = DW'(48'hA5A5_1234_5678);
    present(hold_d, 1'b0, 1'b0, '0, CW'(3), '0);
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(m_tdata == hold_d, "R10", "stalled tdata", 64'(m_tdata), 64'(hold_d));
    chk(m_tvalid == 1'b1, "R10", "stalled tvalid", 64'(m_tvalid), 64'd1);
    chk(sop_err == 1'b0, "R9", "no error while stalled", 64'(sop_err), 64'd0);
    stall_force = 1'b0;
    finish_beat();
    @(negedge clk);
    chk(sop_err == 1'b1, "R7", "missing start flagged", 64'(sop_err), 64'd1);
    @(posedge clk);
    #2;
    send_beat(1'b0, 1'b1, EMW'(2), CW'(3));
    send_pkt(3, CW'(5));
    drain();
    repeat (3) @(negedge clk);
    chk(sop_err == 1'b1, "R8", "error stays set", 64'(sop_err), 64'd1);

    // R7: start flag in the middle of a packet
    do_reset();
    send_beat(1'b1, 1'b0, '0, CW'(7));
    @(negedge clk);
    chk(sop_err == 1'b0, "R7", "good first beat", 64'(sop_err), 64'd0);
    @(posedge clk);
    #2;
    send_beat(1'b1, 1'b1, EMW'(1), CW'(7));
    @(negedge clk);
    chk(sop_err == 1'b1, "R7", "extra start flagged", 64'(sop_err), 64'd1);
    @(posedge clk);
    #2;

    // clean traffic after reset
    do_reset();
    for (int p = 0; p < 30; p++) send_pkt($urandom_range(5, 1), CW'($urandom));
    drain();
    chk(sop_err == 1'b0, "R8", "clear after reset", 64'(sop_err), 64'd0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule